// File: doc/BRIEF.md
# Return Stack and Context Flag Unit

This block keeps the return addresses and the condition flags of a small 8-bit processor core. Return addresses sit in a six-level, 12-bit shift stack with no pointer. A push moves every level one place deeper and puts the current program counter into the top level. A return takes the top level out and moves the rest up one place. The stack saturates at both ends: once it holds six entries, further pushes drop the oldest one. A return on an empty stack leaves it empty and hands back the current PC plus one, so execution simply continues.

Three separate carry/zero pairs exist, one for each execution context: normal, interrupt and non-maskable interrupt. Only the pair of the current context can be written or observed. Entering an interrupt or an NMI switches to that context's pair. The previous context is pushed into a two-deep history, so a return-from-interrupt brings back the pair that was in use before. The instruction decoder and the ALU sit outside the block. They present one-cycle strobes together with the current PC and the new flag values, and they take the returned PC, the active flags and the context from the outputs.

Top module: `ctxReturnUnit`

## Requirements
- R1: While `rstN` is low and after its release, the stack is empty, `ctx` is the NMI code (2), `popPc` equals the reset vector 0xFFE, and all six flags read 0.
- R2: A return (`retEn` or `retiEn`) on a non-empty stack loads `popPc` one cycle later with the most recently pushed PC, and entries come back in last-in, first-out order.
- R3: After more than six pushes the stack holds the six newest values. The oldest are lost, so the seventh return after such a burst sees an empty stack.
- R4: A return on an empty stack sets `popPc` to `curPc` + 1, wrapping modulo 4096 (0xFFF gives 0x000), and the stack stays empty.
- R5: `popPc` keeps its value in every cycle that performs no return, whatever `curPc` does.
- R6: When `pushEn` and a return strobe are high in the same cycle, the push is performed and the return is ignored: `popPc` holds, and the stack contents show this in later returns.
- R7: Context codes are normal = 0, interrupt = 1, NMI = 2. `nmiEntry` makes the context 2 on the next cycle. `intEntry` without `nmiEntry` makes it 1. `nmiEntry` wins when both are high.
- R8: Each entry records the old context in a two-deep history. `retiEn` with no entry in the same cycle restores the newest recorded context and also performs a return. Once the history is used up, or right after reset, `retiEn` yields the normal context.
- R9: `carryWe` loads `carryIn` and `zeroWe` loads `zeroIn` into the pair of the context active in that cycle, each independently. The new value is visible on `carry`/`zero` on the next cycle.
- R10: A context switch neither clears nor alters any pair: returning to a context shows its last written values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| curPc | input | 12 | Current program counter; pushed value and base for the empty-return case |
| pushEn | input | 1 | Push `curPc` (call or interrupt) |
| retEn | input | 1 | Return from subroutine |
| retiEn | input | 1 | Return from interrupt: return plus context restore |
| intEntry | input | 1 | Enter interrupt context |
| nmiEntry | input | 1 | Enter NMI context |
| carryWe | input | 1 | Write the active carry flag |
| zeroWe | input | 1 | Write the active zero flag |
| carryIn | input | 1 | New carry value |
| zeroIn | input | 1 | New zero value |
| popPc | output | 12 | PC produced by the last return, or the reset vector |
| carry | output | 1 | Carry flag of the active context |
| zero | output | 1 | Zero flag of the active context |
| ctx | output | 2 | Active context code |

## Verification
The stack is exercised with short balanced push/pop runs, with bursts of eight pushes followed by seven returns, with returns on an empty stack at a PC of 0xFFF, and with a simultaneous push and return. These patterns separate correct ordering from dropping the wrong end, a missing saturation from a wrapping one, and the right arbitration from the wrong one. Context sequences nest three entries deep and then unwind past the history, and include a simultaneous NMI and interrupt entry. Between switches, flag writes give each pair a different pattern, which exposes a write landing in the wrong pair, a pair cleared on a switch, and a bad restore order. A behavioural model built on queues predicts every output on every cycle.

// File: rtl/ctxStackPkg.sv
package ctxStackPkg;
  localparam int NCTX = 3;

  typedef enum logic [1:0] {
    CTX_NORM = 2'd0,
    CTX_IRQ  = 2'd1,
    CTX_NMI  = 2'd2
  } ctxE;

  typedef struct packed {
    logic push;
    logic pop;
    logic enterIrq;
    logic enterNmi;
    logic restore;
    logic wrC;
    logic wrZ;
  } stackCtrlT;
endpackage

// File: rtl/ctxControl.sv
module ctxControl
  import ctxStackPkg::*;
#(
  parameter int HIST = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      pushEn,
  input  logic      retEn,
  input  logic      retiEn,
  input  logic      intEntry,
  input  logic      nmiEntry,
  input  logic      carryWe,
  input  logic      zeroWe,
  output stackCtrlT strobe,
  output ctxE       ctxQ
);
  ctxE hist [HIST];

  // arbitration: push beats pop, NMI beats IRQ, any entry beats restore
  always_comb begin
    strobe.push     = pushEn;
    strobe.pop      = (retEn | retiEn) & ~pushEn;
    strobe.enterNmi = nmiEntry;
    strobe.enterIrq = intEntry & ~nmiEntry;
    strobe.restore  = retiEn & ~nmiEntry & ~intEntry;
    strobe.wrC      = carryWe;
    strobe.wrZ      = zeroWe;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctxQ <= CTX_NMI;
      for (int i = 0; i < HIST; i++) hist[i] <= CTX_NORM;
    end else if (strobe.enterNmi || strobe.enterIrq) begin
      ctxQ    <= strobe.enterNmi ? CTX_NMI : CTX_IRQ;
      hist[0] <= ctxQ;
      for (int i = 1; i < HIST; i++) hist[i] <= hist[i-1];
    end else if (strobe.restore) begin
      ctxQ <= hist[0];
      for (int i = 0; i < HIST - 1; i++) hist[i] <= hist[i+1];
      hist[HIST-1] <= CTX_NORM;
    end
  end
endmodule

// File: rtl/stackPath.sv
module stackPath
  import ctxStackPkg::*;
#(
  parameter int          DEPTH     = 6,
  parameter int          PC_W      = 12,
  parameter logic [11:0] RESET_VEC = 12'hFFE
) (
  input  logic            clk,
  input  logic            rstN,
  input  stackCtrlT       strobe,
  input  logic [PC_W-1:0] curPc,
  output logic [PC_W-1:0] popPc
);
  localparam logic [PC_W-1:0] ONE = PC_W'(1);

  logic [PC_W-1:0] lvl      [DEPTH];
  logic            vld      [DEPTH];
  logic [PC_W-1:0] fromAbove[DEPTH];
  logic [PC_W-1:0] fromBelow[DEPTH];
  logic            vAbove   [DEPTH];
  logic            vBelow   [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : gLevel
    if (g == 0) begin : gTop
      assign fromAbove[g] = curPc;
      assign vAbove[g]    = 1'b1;
    end else begin : gMid
      assign fromAbove[g] = lvl[g-1];
      assign vAbove[g]    = vld[g-1];
    end
    if (g == DEPTH - 1) begin : gBot
      assign fromBelow[g] = '0;
      assign vBelow[g]    = 1'b0;
    end else begin : gUp
      assign fromBelow[g] = lvl[g+1];
      assign vBelow[g]    = vld[g+1];
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        lvl[g] <= '0;
        vld[g] <= 1'b0;
      end else if (strobe.push) begin
        lvl[g] <= fromAbove[g];
        vld[g] <= vAbove[g];
      end else if (strobe.pop) begin
        lvl[g] <= fromBelow[g];
        vld[g] <= vBelow[g];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)           popPc <= PC_W'(RESET_VEC);
    else if (strobe.pop) popPc <= vld[0] ? lvl[0] : curPc + ONE;
  end
endmodule

// File: rtl/flagBank.sv
module flagBank
  import ctxStackPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  stackCtrlT strobe,
  input  ctxE       ctxQ,
  input  logic      carryIn,
  input  logic      zeroIn,
  output logic      carry,
  output logic      zero
);
  logic [NCTX-1:0] cBank;
  logic [NCTX-1:0] zBank;

  for (genvar b = 0; b < NCTX; b++) begin : gPair
    always_ff @(posedge clk) begin
      if (!rstN) begin
        cBank[b] <= 1'b0;
        zBank[b] <= 1'b0;
      end else if (ctxQ == ctxE'(b)) begin
        if (strobe.wrC) cBank[b] <= carryIn;
        if (strobe.wrZ) zBank[b] <= zeroIn;
      end
    end
  end

  always_comb begin
    unique case (ctxQ)
      CTX_IRQ: begin carry = cBank[1]; zero = zBank[1]; end
      CTX_NMI: begin carry = cBank[2]; zero = zBank[2]; end
      default: begin carry = cBank[0]; zero = zBank[0]; end
    endcase
  end
endmodule

// File: rtl/ctxReturnUnit.sv
module ctxReturnUnit
  import ctxStackPkg::*;
#(
  parameter int          DEPTH     = 6,
  parameter int          PC_W      = 12,
  parameter int          HIST      = 2,
  parameter logic [11:0] RESET_VEC = 12'hFFE
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PC_W-1:0] curPc,
  input  logic            pushEn,
  input  logic            retEn,
  input  logic            retiEn,
  input  logic            intEntry,
  input  logic            nmiEntry,
  input  logic            carryWe,
  input  logic            zeroWe,
  input  logic            carryIn,
  input  logic            zeroIn,
  output logic [PC_W-1:0] popPc,
  output logic            carry,
  output logic            zero,
  output logic [1:0]      ctx
);
  stackCtrlT strobe;
  ctxE       ctxQ;

  ctxControl #(.HIST(HIST)) u_ctrl (
    .clk(clk), .rstN(rstN), .pushEn(pushEn), .retEn(retEn), .retiEn(retiEn),
    .intEntry(intEntry), .nmiEntry(nmiEntry), .carryWe(carryWe), .zeroWe(zeroWe),
    .strobe(strobe), .ctxQ(ctxQ)
  );

  stackPath #(.DEPTH(DEPTH), .PC_W(PC_W), .RESET_VEC(RESET_VEC)) u_stack (
    .clk(clk), .rstN(rstN), .strobe(strobe), .curPc(curPc), .popPc(popPc)
  );

  flagBank u_flags (
    .clk(clk), .rstN(rstN), .strobe(strobe), .ctxQ(ctxQ),
    .carryIn(carryIn), .zeroIn(zeroIn), .carry(carry), .zero(zero)
  );

  assign ctx = ctxQ;
endmodule

// File: rtl/ctxReturnUnitChk.sv
module ctxReturnUnitChk #(
  parameter int PC_W = 12
) (
  input logic            clk,
  input logic            rstN,
  input logic [PC_W-1:0] curPc,
  input logic            pushEn,
  input logic            retEn,
  input logic            retiEn,
  input logic            intEntry,
  input logic            nmiEntry,
  input logic            carryWe,
  input logic            zeroWe,
  input logic            carryIn,
  input logic            zeroIn,
  input logic [PC_W-1:0] popPc,
  input logic            carry,
  input logic            zero,
  input logic [1:0]      ctx
);
  logic anyRet, ctxHold;
  assign anyRet  = retEn | retiEn;
  assign ctxHold = !intEntry && !nmiEntry && !retiEn;

  assert_push_pop_lifo_R2: assert property (@(posedge clk) disable iff (!rstN)
    (pushEn ##1 (anyRet && !pushEn)) |=> popPc == $past(curPc, 2));

  assert_pc_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !anyRet |=> $stable(popPc));

  assert_push_wins_R6: assert property (@(posedge clk) disable iff (!rstN)
    (pushEn && anyRet) |=> $stable(popPc));

  assert_nmi_entry_R7: assert property (@(posedge clk) disable iff (!rstN)
    nmiEntry |=> ctx == 2'd2);

  assert_irq_entry_R7: assert property (@(posedge clk) disable iff (!rstN)
    (intEntry && !nmiEntry) |=> ctx == 2'd1);

  assert_reti_restore_R8: assert property (@(posedge clk) disable iff (!rstN)
    ((nmiEntry || intEntry) ##1 (retiEn && !intEntry && !nmiEntry)) |=> ctx == $past(ctx, 2));

  assert_carry_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    (carryWe && ctxHold) |=> carry == $past(carryIn));

  assert_flags_kept_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!carryWe && !zeroWe && ctxHold) |=> ($stable(carry) && $stable(zero)));
endmodule

bind ctxReturnUnit ctxReturnUnitChk #(.PC_W(PC_W)) u_chk (.*);

// File: tb/ctxReturnUnit_tb.sv
module ctxReturnUnit_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] curPc = '0;
  logic        pushEn = 0, retEn = 0, retiEn = 0, intEntry = 0, nmiEntry = 0;
  logic        carryWe = 0, zeroWe = 0, carryIn = 0, zeroIn = 0;
  logic [11:0] popPc;
  logic        carry, zero;
  logic [1:0]  ctx;

  ctxReturnUnit u_dut (
    .clk(clk), .rstN(rstN), .curPc(curPc), .pushEn(pushEn), .retEn(retEn),
    .retiEn(retiEn), .intEntry(intEntry), .nmiEntry(nmiEntry), .carryWe(carryWe),
    .zeroWe(zeroWe), .carryIn(carryIn), .zeroIn(zeroIn), .popPc(popPc),
    .carry(carry), .zero(zero), .ctx(ctx)
  );

  always #(CLK_P/2) clk = ~clk;

  int    checks = 0;
  int    errors = 0;
  bit    done = 0;
  string curTag = "R1";

  // behavioural reference model
  int stk[$];
  int hist[$];
  int mCtx, mPc;
  int mC[3], mZ[3];

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", curTag, what, act, exp);
    end
  endtask

  task automatic compareAll();
    chk("popPc", int'(popPc), mPc);
    chk("ctx", int'(ctx), mCtx);
    chk("carry", int'(carry), mC[mCtx]);
    chk("zero", int'(zero), mZ[mCtx]);
  endtask

  task automatic clearIn();
    pushEn = 0; retEn = 0; retiEn = 0; intEntry = 0; nmiEntry = 0;
    carryWe = 0; zeroWe = 0;
  endtask

  task automatic tick();
    int pc;
    pc = int'(curPc);
    @(posedge clk);
    if (carryWe) mC[mCtx] = int'(carryIn);
    if (zeroWe)  mZ[mCtx] = int'(zeroIn);
    if (pushEn) begin
      stk.push_front(pc);
      if (stk.size() > 6) void'(stk.pop_back());
    end else if (retEn || retiEn) begin
      if (stk.size() > 0) mPc = stk.pop_front();
      else                mPc = (pc + 1) & 12'hFFF;
    end
    if (nmiEntry || intEntry) begin
      hist.push_front(mCtx);
      void'(hist.pop_back());
      mCtx = nmiEntry ? 2 : 1;
    end else if (retiEn) begin
      mCtx = hist.pop_front();
      hist.push_back(0);
    end
    @(negedge clk);
    compareAll();
    clearIn();
  endtask

  task automatic doPush(int pc);
    curPc = 12'(pc); pushEn = 1; tick();
  endtask

  task automatic doRet(int pc);
    curPc = 12'(pc); retEn = 1; tick();
  endtask

  task automatic setFlags(bit c, bit z);
    carryWe = 1; zeroWe = 1; carryIn = c; zeroIn = z; tick();
  endtask

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    mCtx = 2; mPc = 12'hFFE; hist = '{0, 0};
    for (int i = 0; i < 3; i++) begin mC[i] = 0; mZ[i] = 0; end
    repeat (3) @(negedge clk);
    curTag = "R1";
    compareAll();
    rstN = 1;
    @(negedge clk);
    compareAll();

    // R2 balanced LIFO
    curTag = "R2";
    doPush(12'h111); doPush(12'h222); doPush(12'h333);
    doRet(0); doRet(0); doRet(0);

    // R5 hold with no return while curPc moves
    curTag = "R5";
    for (int i = 0; i < 4; i++) begin curPc = 12'(i * 37 + 5); tick(); end

    // R3 overflow: eight pushes, seven returns
    curTag = "R3";
    for (int i = 1; i <= 8; i++) doPush(i * 16'h101);
    for (int i = 0; i < 7; i++) doRet(12'h500 + i);

    // R4 empty returns, including wrap
    curTag = "R4";
    doRet(12'hFFF);
    doRet(12'h123);

    // R6 push and return together
    curTag = "R6";
    doPush(12'hA00);
    curPc = 12'hB00; pushEn = 1; retEn = 1; tick();
    doRet(0); doRet(0); doRet(0);

    // R7 / R8 context transitions
    curTag = "R8";
    curPc = 12'h010; retiEn = 1; tick();        // after reset -> normal
    curTag = "R9";
    setFlags(1, 0);                             // normal pair = 1,0
    curTag = "R7";
    intEntry = 1; curPc = 12'h020; pushEn = 1; tick();
    curTag = "R9";
    carryWe = 1; carryIn = 0; tick();           // carry only
    zeroWe = 1; zeroIn = 1; tick();             // zero only
    curTag = "R7";
    nmiEntry = 1; intEntry = 1; curPc = 12'h030; pushEn = 1; tick();
    curTag = "R9";
    setFlags(1, 1);                             // nmi pair
    curTag = "R7";
    nmiEntry = 1; tick();                       // third nesting, history overflow
    curTag = "R10";
    setFlags(0, 1);
    curTag = "R8";
    retiEn = 1; tick();                         // -> nmi
    curTag = "R10";
    tick();
    curTag = "R8";
    retiEn = 1; tick();                         // -> irq
    curTag = "R10";
    tick();
    curTag = "R8";
    retiEn = 1; tick();                         // history used up -> normal
    retiEn = 1; tick();
    curTag = "R10";
    intEntry = 1; carryWe = 1; carryIn = 1; tick(); // write lands in normal pair
    curTag = "R8";
    retiEn = 1; intEntry = 1; tick();           // entry wins over restore
    retiEn = 1; tick();
    retiEn = 1; tick();
    curTag = "R10";
    tick();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule